// File: doc/BRIEF.md
# Per-Port Sticky Fault Event Register

This block latches fault events for a four-port power-sourcing controller. Each port reports two kinds of event. The first is a current-limit timeout: the port has held its output at the current limit, or at the folded-back limit, for longer than the allowed time. The second is a start event: a start-up timeout at port turn-on, or a class or detect error during a turn-on started by the standard power-enable command. Each event pulse sets a sticky flag that stays set until it is cleared.

A host reads the flags by presenting a command code.

- One code returns the flags and leaves them unchanged.
- A second code returns the same data and then wipes every flag.
- Turning a port off clears that port's two flags.

A registered interrupt request stays high while any flag whose per-bit enable is set remains set.

Top module: `fault_event_reg`

## Requirements
- R1: After reset, all eight flags, the read bus and the interrupt request are 0.
- R2: A one-cycle pulse on the current-limit input of port p (p = 1..4) sets flag bit 3+p. A pulse on the start input of port p sets flag bit p-1. Every flag stays set once set.
- R3: A command with code 08h returns the flags and leaves them unchanged.
- R4: A command with code 09h returns the flags, and from the next cycle all eight flags are 0.
- R5: A port-off pulse for port p clears bits 3+p and p-1 and leaves the other flags untouched.
- R6: An event arriving in the same cycle as a clear (code 09h or port-off) is kept. Its flag is 1 after that cycle.
- R7: The read bus updates in the cycle after a command is accepted. It shows the flags as they stood before that command's cycle, without events of the same cycle. It holds that value until the next command.
- R8: The interrupt request is registered. It is the OR of the eight flags, each gated by its bit of the enable input. It falls in the cycle after a code-09h clear when no new event arrives.
- R9: Any command code other than 08h or 09h puts 0 on the read bus and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ilim_evt | input | 4 | Current-limit timeout pulses, bit 0 = port 1 |
| start_evt | input | 4 | Start timeout or class/detect error pulses, bit 0 = port 1 |
| port_off | input | 4 | Port turn-off pulses, bit 0 = port 1 |
| cmd_valid | input | 1 | Command accepted this cycle |
| cmd_code | input | 8 | Command code |
| irq_en | input | 8 | Per-flag interrupt enable |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
Two things can land in the same cycle: an event setting a flag, and a clear from either a code-09h read or a port-off pulse. The bench provokes this by driving the event pulse and the clear on the same clock edge. It then judges the outcome in two ways. The returned read data must exclude the new event. A following non-destructive read must show the new flag alone. A read that coincides with an event is also checked, to confirm that the captured data is the pre-event value.

// File: rtl/fault_event_reg.sv
module fault_event_reg #(
  parameter int NPORTS    = 4,
  parameter int CMD_W     = 8,
  parameter logic [CMD_W-1:0] CODE_PEEK  = 8'h08,
  parameter logic [CMD_W-1:0] CODE_CLEAR = 8'h09
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORTS-1:0]     ilim_evt,
  input  logic [NPORTS-1:0]     start_evt,
  input  logic [NPORTS-1:0]     port_off,
  input  logic                  cmd_valid,
  input  logic [CMD_W-1:0]      cmd_code,
  input  logic [2*NPORTS-1:0]   irq_en,
  output logic [2*NPORTS-1:0]   rd_data,
  output logic                  irq
);
  localparam int W = 2 * NPORTS;

  logic [W-1:0] flags, flags_nxt, set_vec, off_vec;
  logic is_peek, is_clear;

  assign set_vec  = {ilim_evt, start_evt};
  assign off_vec  = {port_off, port_off};
  assign is_peek  = cmd_valid && (cmd_code == CODE_PEEK);
  assign is_clear = cmd_valid && (cmd_code == CODE_CLEAR);

  assign flags_nxt = (is_clear ? '0 : (flags & ~off_vec)) | set_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= '0;
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      flags <= flags_nxt;
      irq   <= |(flags_nxt & irq_en);
      if (is_peek || is_clear)
        rd_data <= flags;
      else if (cmd_valid)
        rd_data <= '0;
    end
  end

  AST_PEEK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (is_peek && set_vec == '0 && port_off == '0) |=> $stable(flags)); // R3
  AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_clear && set_vec == '0) |=> flags == '0); // R4
  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (port_off != '0 && set_vec == '0) |=> (flags & {$past(port_off), $past(port_off)}) == '0); // R5
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> (flags & $past(set_vec)) == $past(set_vec)); // R6
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_peek || is_clear) |=> rd_data == $past(flags)); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(rd_data)); // R7
  AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (is_clear && set_vec == '0) |=> !irq); // R8
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !is_peek && !is_clear) |=> rd_data == '0); // R9
endmodule

// File: tb/fault_event_reg_tb.sv
module fault_event_reg_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] ilim_evt = '0, start_evt = '0, port_off = '0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = '0;
  logic [7:0] irq_en = 8'hFF;
  logic [7:0] rd_data;
  logic       irq;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  fault_event_reg u_dut (
    .clk(clk), .rst_n(rst_n), .ilim_evt(ilim_evt), .start_evt(start_evt),
    .port_off(port_off), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk8(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic cyc(logic v, logic [7:0] code, logic [3:0] il, logic [3:0] st, logic [3:0] off);
    @(negedge clk);
    cmd_valid = v; cmd_code = code; ilim_evt = il; start_evt = st; port_off = off;
    @(negedge clk);
    cmd_valid = 1'b0; cmd_code = '0; ilim_evt = '0; start_evt = '0; port_off = '0;
  endtask

  task automatic peek(output logic [7:0] d);
    cyc(1'b1, 8'h08, 4'h0, 4'h0, 4'h0);
    d = rd_data;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk8("R1 rd_data", rd_data, 8'h00);
    chk8("R1 irq", {7'b0, irq}, 8'h00);
    peek(d);
    chk8("R1 flags", d, 8'h00);
  endtask

  task automatic t_set_and_peek();
    logic [7:0] d;
    cyc(1'b0, 8'h00, 4'b0001, 4'b0100, 4'h0);
    chk8("R8 irq set", {7'b0, irq}, 8'h01);
    repeat (3) cyc(1'b0, 8'h00, 4'h0, 4'h0, 4'h0);
    peek(d);
    chk8("R2 layout", d, 8'h14);
    peek(d);
    chk8("R3 peek unchanged", d, 8'h14);
  endtask

  task automatic t_clear();
    logic [7:0] d;
    cyc(1'b1, 8'h09, 4'h0, 4'h0, 4'h0);
    chk8("R4 clear returns data", rd_data, 8'h14);
    chk8("R8 irq released", {7'b0, irq}, 8'h00);
    peek(d);
    chk8("R4 flags cleared", d, 8'h00);
  endtask

  task automatic t_port_off();
    logic [7:0] d;
    cyc(1'b0, 8'h00, 4'hF, 4'hF, 4'h0);
    cyc(1'b0, 8'h00, 4'h0, 4'h0, 4'b0010);
    peek(d);
    chk8("R5 port 2 off", d, 8'hDD);
  endtask

  task automatic t_collide();
    logic [7:0] d;
    cyc(1'b1, 8'h09, 4'b1000, 4'h0, 4'h0);
    chk8("R6 clear read data", rd_data, 8'hDD);
    peek(d);
    chk8("R6 set beats clear", d, 8'h80);
    cyc(1'b0, 8'h00, 4'h0, 4'b0001, 4'b0001);
    peek(d);
    chk8("R6 set beats port off", d, 8'h81);
  endtask

  task automatic t_read_timing();
    cyc(1'b1, 8'h08, 4'h0, 4'b0010, 4'h0);
    chk8("R7 pre-event capture", rd_data, 8'h81);
    repeat (4) cyc(1'b0, 8'h00, 4'h0, 4'h0, 4'h0);
    chk8("R7 rd_data holds", rd_data, 8'h81);
    cyc(1'b0, 8'h00, 4'h0, 4'h0, 4'b0010);
  endtask

  task automatic t_irq_mask();
    @(negedge clk); irq_en = 8'h7E;
    @(negedge clk);
    chk8("R8 masked", {7'b0, irq}, 8'h00);
    irq_en = 8'h01;
    @(negedge clk);
    chk8("R8 enabled bit0", {7'b0, irq}, 8'h01);
    irq_en = 8'hFF;
  endtask

  task automatic t_bad_code();
    logic [7:0] d;
    cyc(1'b1, 8'h0A, 4'h0, 4'h0, 4'h0);
    chk8("R9 bad code data", rd_data, 8'h00);
    cyc(1'b1, 8'h00, 4'h0, 4'h0, 4'h0);
    chk8("R9 code 00 data", rd_data, 8'h00);
    peek(d);
    chk8("R9 flags kept", d, 8'h81);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set_and_peek();
    t_clear();
    t_port_off();
    t_collide();
    t_read_timing();
    t_irq_mask();
    t_bad_code();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule